// File: doc/BRIEF.md
# Two-Wire Control and Status Slave for an Audio Decoder

This block lets a two-wire bus master program the trim and mode settings of a television audio decoder and read back its detector state. It oversamples the clock and data lines with the system clock, finds start, repeated-start and stop conditions, and acknowledges one of two device address pairs chosen by a strap input. A write transaction selects a register with a sub-address byte and then fills consecutive registers, one per data byte.

A read transaction returns one status byte. That byte packs a power-on flag, the stereo flag and a group of detector or calibration flags. Which group appears depends on a filter-test control bit. The register fields leave the block as plain level outputs, and the detector flags enter as plain level inputs. The open-drain data pad is modelled as a single pull-low enable.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: With `addr_sel` low, the slave acknowledges address byte 0x80 (write) and 0x81 (read). With `addr_sel` high, it acknowledges 0x8A (write) and 0x8B (read). Bit 0 of the address byte is the read flag.
- R2: Any other address byte is not acknowledged. All following bytes up to the next start are then ignored: no acknowledge is given and no register changes.
- R3: A write is start, address, sub-address, then any number of data bytes, and the slave acknowledges every byte. Each data byte is written at the sub-address current at that byte.
- R4: The sub-address advances by one after every data byte. It wraps from 0xFF to 0x00.
- R5: Data bytes sent to sub-addresses 0x07 to 0xFF are acknowledged and discarded.
- R6: The register layout is as follows. Sub 0: bits 3:0 `att_lvl`, bit 4 `flt_test`, bit 5 `dac_test`, bit 6 `att_bypass`. Sub 1: bits 5:0 `stvco_trim`. Sub 2: bits 3:0 `sapvco_trim`, bits 7:4 `sapflt_trim`. Sub 3: bits 5:0 `stflt_trim`. Sub 4: bits 5:0 `sep_hi_trim`. Sub 5: bits 5:0 `sep_lo_trim`. Sub 6: bit 0 `mute_off`, bit 1 `sap_cond`, bit 2 `force_mono`, bit 3 `nr_sel`. All other bits are not stored.
- R7: After reset the fields hold the following values. `att_lvl` is 0x9, `stvco_trim` is 0x1F, `sapvco_trim` is 0x8 and `sapflt_trim` is 0x8. `stflt_trim`, `sep_hi_trim` and `sep_lo_trim` are each 0x1F. All 1-bit fields are 0 and `sda_oe` is 0.
- R8: When `flt_test` is 0, the status byte is as follows. Bit 7 is the power-on flag, bit 6 `stereo_det`, bit 5 `sap_det`, bit 4 `noise_det`, bits 3:2 are zero, bit 1 `sapvco_lo` and bit 0 `sapvco_hi`.
- R9: When `flt_test` is 1, bit 5 becomes `stflt_ok` and bit 4 becomes `sapflt_ok`, and bits 3:0 all read zero. Bits 7 and 6 keep their R8 meaning.
- R10: The power-on flag is 1 after reset. It clears once a status read has completed its master-acknowledge bit, whether the master sent ACK or NACK.
- R11: The slave changes `sda_oe` only while the synchronized clock line is low, so each read bit is stable for the whole high phase. It releases the line after a stop.
- R12: A repeated start ends a write and begins a new transaction with an address byte. A read after a repeated start returns the status byte. The slave releases the line at any start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Chooses the device address pair |
| stereo_det | input | 1 | Stereo pilot detected |
| sap_det | input | 1 | Second-program carrier detected |
| noise_det | input | 1 | Excess noise detected |
| sapvco_lo | input | 1 | Second-program VCO calibration flag 1 |
| sapvco_hi | input | 1 | Second-program VCO calibration flag 2 |
| stflt_ok | input | 1 | Stereo filter within calibration window |
| sapflt_ok | input | 1 | Second-program filter within calibration window |
| att_lvl | output | 4 | Input attenuation setting |
| att_bypass | output | 1 | Bypass the input attenuator |
| dac_test | output | 1 | Converter test mode |
| flt_test | output | 1 | Filter calibration mode |
| stvco_trim | output | 6 | Stereo VCO trim |
| sapvco_trim | output | 4 | Second-program VCO trim |
| sapflt_trim | output | 4 | Second-program filter trim |
| stflt_trim | output | 6 | Stereo filter trim |
| sep_hi_trim | output | 6 | High-frequency separation trim |
| sep_lo_trim | output | 6 | Low-frequency separation trim |
| nr_sel | output | 1 | Noise-reduction source select |
| force_mono | output | 1 | Force mono output |
| sap_cond | output | 1 | Second-program selection condition |
| mute_off | output | 1 | 1 unmutes the outputs |

## Verification
The bench sweeps sixteen address bytes under both strap settings and checks each acknowledge. A slave that compared all eight bits, or ignored the strap, would acknowledge the wrong byte. Another failure would be a slave that reacted to the data bytes sent after a refused address.

Write bursts start at every sub-address from 0 through 8, plus 0xFF. They catch three faults: a pointer that does not advance, a bank that lets bytes beyond sub 6 land in a register, and a pointer that does not wrap to sub 0.

The status byte is read 128 times with varied detector inputs in both filter-test modes. A swapped or stale status mux shows up as a wrong bit. A slave that changed the line during the clock-high phase shows up as a bit that differs between the start and the end of that phase.

The power-on flag must read 1 on the first read and 0 on the second. A write followed by a repeated start and a read checks that the write lands and that the read still returns the status byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int NUM_REGS = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } bus_st_t;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0: return 8'h09;
      1: return 8'h1F;
      2: return 8'h88;
      3: return 8'h1F;
      4: return 8'h1F;
      5: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0: return 8'h7F;
      2: return 8'hFF;
      6: return 8'h0F;
      default: return 8'h3F;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] raw;
  logic [1:0] syn;
  logic       scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign syn[g] = chain[STAGES-1];
  end

  assign scl_s = syn[1];
  assign sda_s = syn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'h80,
  parameter logic [7:0] ADDR_HI = 8'h8A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       read_done
);
  localparam logic [6:0] DEV_LO = ADDR_LO[7:1];
  localparam logic [6:0] DEV_HI = ADDR_HI[7:1];

  bus_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, sub;
  logic       rw;
  logic [6:0] dev;

  assign dev = addr_sel ? DEV_HI : DEV_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; sub <= '0; rw <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      read_done <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      read_done <= 1'b0;
      if (start_evt) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == dev) begin
                  sda_oe <= 1'b1; rw <= sh[0]; st <= ST_AACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_SUB) begin
                sub <= sh; sda_oe <= 1'b1; st <= ST_SACK;
              end else begin
                wr_en <= 1'b1; wr_addr <= sub; wr_data <= sh;
                sub <= sub + 8'd1; sda_oe <= 1'b1; st <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx <= status_byte; sda_oe <= ~status_byte[7]; st <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0; st <= ST_SUB;
              end
            end
          end
          ST_SACK, ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= ST_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              read_done <= 1'b1; st <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  read_done,
  input  logic [6:0]            det_flags,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic [7:0]            status_byte,
  output logic                  por
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reg_q[g*8 +: 8] <= reg_default(g);
      else if (wr_en && wr_addr == 8'(g))
        reg_q[g*8 +: 8] <= wr_data & reg_mask(g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         por <= 1'b1;
    else if (read_done) por <= 1'b0;
  end

  logic ftest;
  assign ftest = reg_q[4];

  // det_flags: {stereo, sap, noise, vco_lo, vco_hi, stflt_ok, sapflt_ok}
  always_comb begin
    status_byte[7]   = por;
    status_byte[6]   = det_flags[6];
    status_byte[5]   = ftest ? det_flags[1] : det_flags[5];
    status_byte[4]   = ftest ? det_flags[0] : det_flags[4];
    status_byte[3:2] = 2'b00;
    status_byte[1:0] = ftest ? 2'b00 : det_flags[3:2];
  end
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
  import i2cs_pkg::*;
#(
  parameter logic [7:0] ADDR_LO     = 8'h80,
  parameter logic [7:0] ADDR_HI     = 8'h8A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  input  logic       stereo_det,
  input  logic       sap_det,
  input  logic       noise_det,
  input  logic       sapvco_lo,
  input  logic       sapvco_hi,
  input  logic       stflt_ok,
  input  logic       sapflt_ok,
  output logic [3:0] att_lvl,
  output logic       att_bypass,
  output logic       dac_test,
  output logic       flt_test,
  output logic [5:0] stvco_trim,
  output logic [3:0] sapvco_trim,
  output logic [3:0] sapflt_trim,
  output logic [5:0] stflt_trim,
  output logic [5:0] sep_hi_trim,
  output logic [5:0] sep_lo_trim,
  output logic       nr_sel,
  output logic       force_mono,
  output logic       sap_cond,
  output logic       mute_off
);
  logic                  scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic                  wr_en, read_done, por;
  logic [7:0]            wr_addr, wr_data, status_byte;
  logic [NUM_REGS*8-1:0] reg_q;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_proto #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_proto (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .status_byte(status_byte), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .read_done(read_done)
  );

  i2cs_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .read_done(read_done),
    .det_flags({stereo_det, sap_det, noise_det, sapvco_lo, sapvco_hi,
                stflt_ok, sapflt_ok}),
    .reg_q(reg_q), .status_byte(status_byte), .por(por)
  );

  assign att_lvl     = reg_q[3:0];
  assign flt_test    = reg_q[4];
  assign dac_test    = reg_q[5];
  assign att_bypass  = reg_q[6];
  assign stvco_trim  = reg_q[13:8];
  assign sapvco_trim = reg_q[19:16];
  assign sapflt_trim = reg_q[23:20];
  assign stflt_trim  = reg_q[29:24];
  assign sep_hi_trim = reg_q[37:32];
  assign sep_lo_trim = reg_q[45:40];
  assign mute_off    = reg_q[48];
  assign sap_cond    = reg_q[49];
  assign force_mono  = reg_q[50];
  assign nr_sel      = reg_q[51];
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  sda_oe,
  input logic                  read_done,
  input logic                  por,
  input logic                  wr_en,
  input logic [7:0]            wr_addr,
  input logic [NUM_REGS*8-1:0] reg_q
);
  p_release_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_release_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  p_por_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(read_done));

  p_drop_high_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 8'(NUM_REGS)) |=> $stable(reg_q));
endmodule

bind i2c_ctrl_slave i2cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .read_done(read_done), .por(por),
  .wr_en(wr_en), .wr_addr(wr_addr), .reg_q(reg_q)
);

// File: tb/tb_i2c_ctrl_slave.sv
module tb_i2c_ctrl_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [6:0] fl = '0;
  logic sda_oe;
  logic [3:0] att_lvl, sapvco_trim, sapflt_trim;
  logic att_bypass, dac_test, flt_test, nr_sel, force_mono, sap_cond, mute_off;
  logic [5:0] stvco_trim, stflt_trim, sep_hi_trim, sep_lo_trim;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_ctrl_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .stereo_det(fl[6]), .sap_det(fl[5]), .noise_det(fl[4]),
    .sapvco_lo(fl[3]), .sapvco_hi(fl[2]), .stflt_ok(fl[1]), .sapflt_ok(fl[0]),
    .att_lvl(att_lvl), .att_bypass(att_bypass), .dac_test(dac_test),
    .flt_test(flt_test), .stvco_trim(stvco_trim), .sapvco_trim(sapvco_trim),
    .sapflt_trim(sapflt_trim), .stflt_trim(stflt_trim), .sep_hi_trim(sep_hi_trim),
    .sep_lo_trim(sep_lo_trim), .nr_sel(nr_sel), .force_mono(force_mono),
    .sap_cond(sap_cond), .mute_off(mute_off)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] mdl [0:6];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] msk(input int a);
    case (a)
      0: return 8'h7F;
      2: return 8'hFF;
      6: return 8'h0F;
      default: return 8'h3F;
    endcase
  endfunction

  function automatic logic [42:0] act_fields();
    return {att_bypass, dac_test, flt_test, att_lvl, stvco_trim, sapflt_trim,
            sapvco_trim, stflt_trim, sep_hi_trim, sep_lo_trim,
            nr_sel, force_mono, sap_cond, mute_off};
  endfunction

  function automatic logic [42:0] exp_fields();
    return {mdl[0][6], mdl[0][5], mdl[0][4], mdl[0][3:0], mdl[1][5:0],
            mdl[2][7:4], mdl[2][3:0], mdl[3][5:0], mdl[4][5:0], mdl[5][5:0],
            mdl[6][3], mdl[6][2], mdl[6][1], mdl[6][0]};
  endfunction

  function automatic logic [7:0] exp_status(input logic por, input logic ft,
                                            input logic [6:0] f);
    return {por, f[6], ft ? f[1] : f[5], ft ? f[0] : f[4], 2'b00,
            ft ? 2'b00 : f[3:2]};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wt(Q); sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(2*Q); sda_m = 1'b0; wt(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wt(Q); sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(2*Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(2*Q); scl_m = 1'b1; wt(Q); ack = sda_line; wt(Q); scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b, inout logic glitch);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic s1;
      wt(2*Q); scl_m = 1'b1; wt(1); s1 = sda_line; wt(2*Q-2);
      if (sda_line !== s1) glitch = 1'b1;
      b[i] = s1; wt(1); scl_m = 1'b0;
    end
    wt(Q); sda_m = mack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] ab, input logic [7:0] sub, input int n,
                       input logic [7:0] seed, input bit upd,
                       output logic aack, output logic any_ack);
    logic a;
    any_ack = 1'b0;
    bus_start();
    wbyte(ab, aack);
    wbyte(sub, a); if (!a) any_ack = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      logic [7:0] adr;
      d = seed + 8'(37 * k);
      adr = sub + 8'(k);
      wbyte(d, a); if (!a) any_ack = 1'b1;
      if (upd && adr < 8'd7) mdl[adr] = d & msk(int'(adr));
    end
    bus_stop();
  endtask

  task automatic rd_tx(input logic [7:0] ab, output logic ack,
                       output logic [7:0] st, inout logic glitch);
    bus_start();
    wbyte(ab, ack);
    if (!ack) rbyte(1'b1, st, glitch);
    else st = 8'hxx;
    bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic ack, aa, anya, gl;
    logic [7:0] st;
    mdl[0] = 8'h09; mdl[1] = 8'h1F; mdl[2] = 8'h88; mdl[3] = 8'h1F;
    mdl[4] = 8'h1F; mdl[5] = 8'h1F; mdl[6] = 8'h00;
    gl = 1'b0;
    wt(10); rst_n = 1'b1; wt(5);

    // R7 reset state
    check(act_fields() === exp_fields(), "R7 defaults", 64'(act_fields()), 64'(exp_fields()));
    check(sda_oe === 1'b0, "R7 sda_oe idle", 64'(sda_oe), 0);

    // R10 power-on flag
    fl = 7'h55;
    rd_tx(8'h81, ack, st, gl);
    check(ack === 1'b0, "R1 read ack", 64'(ack), 0);
    check(st === exp_status(1'b1, 1'b0, fl), "R10 por first read", 64'(st), 64'(exp_status(1'b1, 1'b0, fl)));
    rd_tx(8'h81, ack, st, gl);
    check(st === exp_status(1'b0, 1'b0, fl), "R10 por cleared", 64'(st), 64'(exp_status(1'b0, 1'b0, fl)));

    // R1 / R2 address sweep
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int v = 0; v < 16; v++) begin
        logic [7:0] ab;
        logic eack;
        ab = 8'h80 | 8'(v);
        eack = (ab[7:1] == (sel != 0 ? 7'h45 : 7'h40));
        if (ab[0] && eack) begin
          rd_tx(ab, ack, st, gl);
          check(ack === 1'b0, "R1 read address ack", 64'(ack), 0);
        end else begin
          wr_tx(ab, 8'h00, 2, 8'h3C, eack, aa, anya);
          check(aa === !eack, "R1 address ack", 64'(aa), 64'(!eack));
          if (!eack) begin
            check(anya === 1'b0, "R2 ignored bytes", 64'(anya), 0);
            check(act_fields() === exp_fields(), "R2 no change", 64'(act_fields()), 64'(exp_fields()));
          end
        end
      end
    end
    addr_sel = 1'b0;

    // R3 / R4 / R5 / R6 write sweep
    for (int s = 0; s <= 9; s++) begin
      logic [7:0] sb;
      sb = (s == 9) ? 8'hFF : 8'(s);
      wr_tx(8'h80, sb, 3, 8'(s * 29 + 5), 1'b1, aa, anya);
      check(aa === 1'b0 && anya === 1'b1, "R3 R5 all acked", 64'({aa, anya}), 64'(2'b01));
      check(act_fields() === exp_fields(), "R4 R6 fields", 64'(act_fields()), 64'(exp_fields()));
    end
    wr_tx(8'h80, 8'h00, 7, 8'hA5, 1'b1, aa, anya);
    check(act_fields() === exp_fields(), "R4 full bank", 64'(act_fields()), 64'(exp_fields()));

    // R8 / R9 status sweep
    for (int ft = 0; ft < 2; ft++) begin
      wr_tx(8'h80, 8'h00, 1, 8'h09 | 8'(ft << 4), 1'b1, aa, anya);
      check(flt_test === ft[0], "R6 flt_test bit", 64'(flt_test), 64'(ft));
      for (int i = 0; i < 64; i++) begin
        logic [7:0] e;
        fl = {i[5:0], ~i[0]};
        rd_tx(8'h81, ack, st, gl);
        e = exp_status(1'b0, ft[0], fl);
        check(st === e, ft != 0 ? "R9 status test" : "R8 status normal", 64'(st), 64'(e));
      end
    end
    check(gl === 1'b0, "R11 stable during clock high", 64'(gl), 0);
    check(sda_oe === 1'b0, "R11 released after stop", 64'(sda_oe), 0);

    // R12 repeated start
    fl = 7'h2B;
    bus_start();
    wbyte(8'h80, aa); wbyte(8'h03, aa); wbyte(8'h2A, aa);
    mdl[3] = 8'h2A & msk(3);
    bus_start();
    wbyte(8'h81, ack);
    rbyte(1'b1, st, gl);
    bus_stop();
    check(ack === 1'b0, "R12 ack after repeated start", 64'(ack), 0);
    check(act_fields() === exp_fields(), "R12 write landed", 64'(act_fields()), 64'(exp_fields()));
    check(st === exp_status(1'b0, 1'b1, fl), "R12 status", 64'(st), 64'(exp_status(1'b0, 1'b1, fl)));

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule